// File: doc/BRIEF.md
# Cache Line Zero and Invalidate-Probe Engine

This engine performs two line-granular memory maintenance operations for a processor's load/store path. A *zero* command clears one whole cache line in memory: the command address is rounded down to the start of its line, and a run of 32-bit stores of value zero is issued from the first word to the last. The store run is followed by a check of the load-reservation address. When the reservation points at the line just cleared, a kill pulse is raised so that the reservation holder can discard it, i.e. set it to all ones.

An *invalidate probe* command rounds the address down to its line in the same way. It then issues exactly one 32-bit read at that line address and no write. The memory system therefore checks the access as an ordinary load. The line size comes from a configuration input. For the short-form zero command, a 2-bit mode field can force a 32-byte line.

Commands are taken one at a time through a valid/ready pair. Memory accesses use a request/grant pair that may stall for any number of cycles. Completion is marked by a single-cycle done pulse.

Top module: `cbz_engine`

## Requirements
- R1: Out of reset, and after any reset during an operation, cmd_ready is 1 and mem_req, done and resv_kill are 0.
- R2: The first memory access of any command goes to the command address with its low log2(L) bits cleared, where L is the effective line size in bytes.
- R3: A zero command issues exactly L/4 write requests (mem_we=1, mem_wdata=0) at consecutive word addresses, starting at the aligned line address and rising by 4.
- R4: cfg_line_bytes holds the line size in bytes. The values 32, 64 and 128 are used as given, and any other value is treated as 32.
- R5: For a zero command with cmd_long=0 and cmd_mode=1, L is 32 whatever the configuration. With cmd_long=1, or any other mode value, cmd_mode has no effect.
- R6: An invalidate command (cmd_op=1) issues exactly one read request (mem_we=0) at the address aligned to the configured line size. Mode and long-form inputs do not change it, and it issues no write.
- R7: resv_kill is a one-cycle pulse, raised together with done, and only for a zero command whose aligned line address equals resv_addr at the time the last store is granted. It is never raised for an invalidate command or for any other reservation address.
- R8: done is high for exactly one cycle, in the cycle right after the grant of the final memory access.
- R9: While mem_req is high and mem_gnt is low, the request stays high and mem_addr and mem_we hold their values.
- R10: cmd_ready is 0 from the cycle after a command is accepted through the done cycle. A command offered during that time is never accepted and causes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle; command accepted when valid and ready |
| cmd_op | input | 1 | 0 = zero line, 1 = invalidate probe |
| cmd_addr | input | 32 | Effective address of the command |
| cmd_long | input | 1 | Long-form zero: always use the configured size |
| cmd_mode | input | 2 | Mode field; value 1 forces a 32-byte line for the short form |
| cfg_line_bytes | input | 8 | Configured line size in bytes |
| resv_addr | input | 32 | Current load-reservation address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data (always zero) |
| mem_gnt | input | 1 | Memory accepts the current request |
| resv_kill | output | 1 | Invalidate the load reservation |
| done | output | 1 | Command complete, one cycle |

## Verification
The reservation kill and the done pulse are meant to fall in the same cycle, right after the last zero store is granted. The kill must not appear earlier, while stores are still outstanding. To provoke this, the bench places the reservation at the aligned line address and also at a nearby word of the same line and at all ones. It zeroes lines with and without grant stalls. In the done cycle it checks both outputs together and counts the stores that were granted before them. A command held at the input through that same done cycle must not be taken.

// File: rtl/cbz_pkg.sv
package cbz_pkg;

   typedef enum logic {
      CBZ_OP_ZERO  = 1'b0,
      CBZ_OP_PROBE = 1'b1
   } cbz_op_e;

   typedef enum logic [1:0] {
      CBZ_IDLE = 2'd0,
      CBZ_RUN  = 2'd1,
      CBZ_DONE = 2'd2
   } cbz_state_e;

   localparam logic [1:0] CBZ_MODE_FORCE_SMALL = 2'd1;

   localparam int unsigned CBZ_WORD_BYTES = 4;

endpackage

// File: rtl/cbz_size_sel.sv
module cbz_size_sel #(
   parameter int unsigned CFGW        = 8,
   parameter int unsigned MIN_LINE    = 32,
   parameter int unsigned MAX_LINE    = 128,
   parameter int unsigned FORCED_LINE = 32,
   localparam int unsigned LBW        = $clog2(MAX_LINE) + 1,
   localparam int unsigned NSIZES     = $clog2(MAX_LINE) - $clog2(MIN_LINE) + 1
) (
   input  logic [CFGW-1:0] cfg_bytes,
   input  logic            is_zero,
   input  logic            long_form,
   input  logic [1:0]      mode,
   output logic [LBW-1:0]  line_bytes
);
   import cbz_pkg::*;

   initial begin
      if ((MIN_LINE & (MIN_LINE - 1)) != 0 || (MAX_LINE & (MAX_LINE - 1)) != 0)
         $error("cbz_size_sel: line sizes must be powers of two");
      if (MIN_LINE < CBZ_WORD_BYTES || MAX_LINE < MIN_LINE)
         $error("cbz_size_sel: bad line size range");
      if (MAX_LINE >= (1 << CFGW))
         $error("cbz_size_sel: configuration field too narrow");
      if (FORCED_LINE < MIN_LINE || FORCED_LINE > MAX_LINE)
         $error("cbz_size_sel: forced size outside range");
   end

   logic [NSIZES-1:0]  size_hit;
   logic [LBW-1:0]     size_val [NSIZES];

   for (genvar k = 0; k < NSIZES; k++) begin : g_size
      localparam int unsigned SZ = MIN_LINE << k;
      assign size_val[k] = LBW'(SZ);
      assign size_hit[k] = (cfg_bytes == CFGW'(SZ));
   end

   logic [LBW-1:0] cfg_line;

   always_comb begin
      cfg_line = LBW'(MIN_LINE);
      for (int k = 0; k < NSIZES; k++) begin
         if (size_hit[k]) cfg_line = size_val[k];
      end
   end

   always_comb begin
      if (is_zero && !long_form && mode == CBZ_MODE_FORCE_SMALL)
         line_bytes = LBW'(FORCED_LINE);
      else
         line_bytes = cfg_line;
   end

endmodule

// File: rtl/cbz_align.sv
module cbz_align #(
   parameter int unsigned AW  = 32,
   parameter int unsigned LBW = 8
) (
   input  logic [AW-1:0]  addr,
   input  logic [LBW-1:0] line_bytes,
   output logic [AW-1:0]  line_base
);
   initial begin
      if (AW <= LBW) $error("cbz_align: address narrower than line field");
   end

   logic [AW-1:0] low_mask;

   always_comb begin
      low_mask  = AW'(line_bytes) - AW'(1);
      line_base = addr & ~low_mask;
   end

endmodule

// File: rtl/cbz_seq.sv
module cbz_seq #(
   parameter int unsigned AW  = 32,
   parameter int unsigned LBW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           start_zero,
   input  logic [AW-1:0]  start_base,
   input  logic [LBW-1:0] start_bytes,
   input  logic [AW-1:0]  resv_addr,
   input  logic           mem_gnt,
   output logic           idle,
   output logic           mem_req,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic           done,
   output logic           resv_kill
);
   import cbz_pkg::*;

   cbz_state_e     state_q;
   logic [AW-1:0]  base_q;
   logic [LBW-1:0] off_q;
   logic [LBW-1:0] last_off_q;
   logic           zero_q;
   logic           kill_q;
   logic           final_beat;

   assign final_beat = !zero_q || (off_q == last_off_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= CBZ_IDLE;
         base_q     <= '0;
         off_q      <= '0;
         last_off_q <= '0;
         zero_q     <= 1'b0;
         kill_q     <= 1'b0;
      end else begin
         unique case (state_q)
            CBZ_IDLE: begin
               kill_q <= 1'b0;
               if (start) begin
                  base_q     <= start_base;
                  off_q      <= '0;
                  last_off_q <= start_bytes - LBW'(CBZ_WORD_BYTES);
                  zero_q     <= start_zero;
                  state_q    <= CBZ_RUN;
               end
            end
            CBZ_RUN: begin
               if (mem_gnt) begin
                  if (final_beat) begin
                     state_q <= CBZ_DONE;
                     kill_q  <= zero_q && (resv_addr == base_q);
                  end else begin
                     off_q <= off_q + LBW'(CBZ_WORD_BYTES);
                  end
               end
            end
            CBZ_DONE: begin
               state_q <= CBZ_IDLE;
               kill_q  <= 1'b0;
            end
            default: begin
               state_q <= CBZ_IDLE;
               kill_q  <= 1'b0;
            end
         endcase
      end
   end

   assign idle      = (state_q == CBZ_IDLE);
   assign mem_req   = (state_q == CBZ_RUN);
   assign done      = (state_q == CBZ_DONE);
   assign mem_we    = zero_q;
   assign mem_addr  = base_q + AW'(off_q);
   assign resv_kill = kill_q;

endmodule

// File: rtl/cbz_engine.sv
module cbz_engine #(
   parameter int unsigned AW          = 32,
   parameter int unsigned DW          = 32,
   parameter int unsigned CFGW        = 8,
   parameter int unsigned MIN_LINE    = 32,
   parameter int unsigned MAX_LINE    = 128,
   parameter int unsigned FORCED_LINE = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   output logic            cmd_ready,
   input  logic            cmd_op,
   input  logic [AW-1:0]   cmd_addr,
   input  logic            cmd_long,
   input  logic [1:0]      cmd_mode,
   input  logic [CFGW-1:0] cfg_line_bytes,
   input  logic [AW-1:0]   resv_addr,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   input  logic            mem_gnt,
   output logic            resv_kill,
   output logic            done
);
   import cbz_pkg::*;

   localparam int unsigned LBW = $clog2(MAX_LINE) + 1;

   initial begin
      if (DW != 8 * CBZ_WORD_BYTES) $error("cbz_engine: data width must be one word");
   end

   logic           is_zero;
   logic           accept;
   logic [LBW-1:0] eff_bytes;
   logic [AW-1:0]  aligned;

   assign is_zero = (cbz_op_e'(cmd_op) == CBZ_OP_ZERO);
   assign accept  = cmd_valid && cmd_ready;

   cbz_size_sel #(
      .CFGW(CFGW), .MIN_LINE(MIN_LINE), .MAX_LINE(MAX_LINE), .FORCED_LINE(FORCED_LINE)
   ) u_size (
      .cfg_bytes (cfg_line_bytes),
      .is_zero   (is_zero),
      .long_form (cmd_long),
      .mode      (cmd_mode),
      .line_bytes(eff_bytes)
   );

   cbz_align #(.AW(AW), .LBW(LBW)) u_align (
      .addr      (cmd_addr),
      .line_bytes(eff_bytes),
      .line_base (aligned)
   );

   cbz_seq #(.AW(AW), .LBW(LBW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .start_zero (is_zero),
      .start_base (aligned),
      .start_bytes(eff_bytes),
      .resv_addr  (resv_addr),
      .mem_gnt    (mem_gnt),
      .idle       (cmd_ready),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .done       (done),
      .resv_kill  (resv_kill)
   );

   assign mem_wdata = '0;

endmodule

// File: rtl/cbz_checker.sv
module cbz_checker #(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_ready,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic          mem_gnt,
   input logic          resv_kill,
   input logic          done
);
   a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req || done) |-> !cmd_ready);

   a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_done_no_access: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req);

   a_r7_kill_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      resv_kill |-> (done && mem_we));

   a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   a_r3_word_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt && mem_we) |=> (done || mem_addr == $past(mem_addr) + AW'(4)));

   a_r3_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_wdata == '0));

   a_r6_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt && !mem_we) |=> done);

   a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

endmodule

bind cbz_engine cbz_checker #(.AW(AW), .DW(DW)) u_cbz_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_ready(cmd_ready),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .mem_wdata(mem_wdata),
   .mem_gnt  (mem_gnt),
   .resv_kill(resv_kill),
   .done     (done)
);

// File: tb/test_cbz_engine.sv
module test_cbz_engine;

   typedef struct packed {
      logic        op;
      logic        lng;
      logic [1:0]  mode;
      logic [7:0]  cfg;
      logic [31:0] addr;
      logic [1:0]  rsel;   // 0: aligned base, 1: base+4, 2: all ones
      logic        stall;
      logic [31:0] exp_base;
      logic [7:0]  exp_words;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b1, 2'd0, 8'd32,  32'h1000_0047, 2'd0, 1'b0, 32'h1000_0040, 8'd8},
      '{1'b0, 1'b0, 2'd1, 8'd128, 32'h2000_00F4, 2'd1, 1'b0, 32'h2000_00E0, 8'd8},
      '{1'b0, 1'b1, 2'd1, 8'd128, 32'h2000_00F4, 2'd0, 1'b1, 32'h2000_0080, 8'd32},
      '{1'b0, 1'b0, 2'd2, 8'd64,  32'h3000_007C, 2'd0, 1'b0, 32'h3000_0040, 8'd16},
      '{1'b0, 1'b1, 2'd0, 8'd48,  32'h4000_003F, 2'd2, 1'b0, 32'h4000_0020, 8'd8},
      '{1'b1, 1'b0, 2'd0, 8'd64,  32'h5000_0077, 2'd0, 1'b1, 32'h5000_0040, 8'd1},
      '{1'b1, 1'b0, 2'd1, 8'd128, 32'h6000_00FF, 2'd0, 1'b0, 32'h6000_0080, 8'd1},
      '{1'b0, 1'b0, 2'd3, 8'd128, 32'h0000_0000, 2'd0, 1'b1, 32'h0000_0000, 8'd32}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic        cmd_op = 1'b0;
   logic [31:0] cmd_addr = '0;
   logic        cmd_long = 1'b0;
   logic [1:0]  cmd_mode = '0;
   logic [7:0]  cfg_line_bytes = 8'd32;
   logic [31:0] resv_addr = '1;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_gnt = 1'b0;
   logic        resv_kill;
   logic        done;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   cbz_engine i_cbz_engine (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_long(cmd_long), .cmd_mode(cmd_mode),
      .cfg_line_bytes(cfg_line_bytes), .resv_addr(resv_addr), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
      .resv_kill(resv_kill), .done(done)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_vec(input int v);
      vec_t t = VEC[v];
      int nacc = 0;
      int cyc = 0;
      int last_acc = -10;
      bit saw_done = 0;
      logic exp_kill = (t.op == 1'b0) && (t.rsel == 2'd0);
      @(negedge clk);
      cmd_op = t.op; cmd_long = t.lng; cmd_mode = t.mode;
      cfg_line_bytes = t.cfg; cmd_addr = t.addr; cmd_valid = 1'b1;
      resv_addr = (t.rsel == 2'd0) ? t.exp_base :
                  (t.rsel == 2'd1) ? t.exp_base + 32'd4 : 32'hFFFF_FFFF;
      check("R10 ready while idle", {31'd0, cmd_ready}, 32'd1);
      @(negedge clk);
      // offer a second command that must be held off (R10)
      cmd_op = 1'b1; cmd_addr = 32'hDEAD_0000; cmd_long = 1'b1;
      while (cyc < 400) begin
         if (done) begin saw_done = 1; break; end
         if (mem_req) begin
            check($sformatf("R2/R3 addr vec%0d beat%0d", v, nacc), mem_addr,
                  t.exp_base + 32'(nacc * 4));
            check("R3/R6 direction", {31'd0, mem_we}, {31'd0, ~t.op});
            if (mem_we) check("R3 zero data", mem_wdata, 32'd0);
            check("R10 ready low busy", {31'd0, cmd_ready}, 32'd0);
            check("R7 no early kill", {31'd0, resv_kill}, 32'd0);
         end
         mem_gnt = t.stall ? cyc[0] : 1'b1;
         if (mem_req && mem_gnt) begin nacc++; last_acc = cyc; end
         cyc++;
         @(negedge clk);
      end
      mem_gnt = 1'b0;
      check($sformatf("R8 done seen vec%0d", v), {31'd0, saw_done}, 32'd1);
      check($sformatf("R3/R4/R5/R6 access count vec%0d", v), 32'(nacc), 32'(t.exp_words));
      check("R8 done right after final grant", 32'(cyc - last_acc), 32'd1);
      check($sformatf("R7 kill with done vec%0d", v), {31'd0, resv_kill}, {31'd0, exp_kill});
      check("R10 ready low in done cycle", {31'd0, cmd_ready}, 32'd0);
      cmd_valid = 1'b0;
      @(negedge clk);
      check("R8 done one cycle", {31'd0, done}, 32'd0);
      check("R7 kill one cycle", {31'd0, resv_kill}, 32'd0);
      check("R10 held-off command ignored", {31'd0, mem_req}, 32'd0);
      check("R10 ready after done", {31'd0, cmd_ready}, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset ready", {31'd0, cmd_ready}, 32'd1);
      check("R1 reset req", {31'd0, mem_req}, 32'd0);
      check("R1 reset done", {31'd0, done}, 32'd0);
      check("R1 reset kill", {31'd0, resv_kill}, 32'd0);

      for (int v = 0; v < NV; v++) run_vec(v);

      // R9: stalled request keeps its address
      @(negedge clk);
      cmd_op = 1'b0; cmd_long = 1'b1; cmd_mode = 2'd0; cfg_line_bytes = 8'd64;
      cmd_addr = 32'h7000_0010; cmd_valid = 1'b1; mem_gnt = 1'b0;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 stall keeps req", {31'd0, mem_req}, 32'd1);
      check("R9 stall keeps addr", mem_addr, 32'h7000_0000);
      mem_gnt = 1'b1;
      repeat (2) @(negedge clk);
      mem_gnt = 1'b0;
      // R1: reset in the middle of a run
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 mid-run reset req", {31'd0, mem_req}, 32'd0);
      check("R1 mid-run reset ready", {31'd0, cmd_ready}, 32'd1);
      check("R1 mid-run reset done", {31'd0, done}, 32'd0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog R8 actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule